// File: doc/BRIEF.md
# Three-Phase Threshold-Pulsed Energy Accumulator

This block turns a stream of per-phase voltage and current samples into counted energy quanta. On every cycle where the sample strobe is high, it forms the instantaneous power of each of three phases and adds it to a wide signed accumulator for that phase. The strobe nominally fires once every 125 µs, which is an 8 kHz rate. Whenever an accumulator reaches a programmable positive threshold, one quantum is counted up in that phase's signed energy register and the threshold amount is taken out of the accumulator. Reaching the negative threshold counts one quantum down and adds the threshold back. The energy registers therefore track net positive and negative energy in units of the threshold.

A two-bit combination select suits the block to different three-phase service wirings. In these wirings the middle phase is either measured directly, suppressed, or has its voltage inferred from the other two phases. Each energy register raises a sticky flag when its magnitude first enters the upper half of its range. Software clears a flag by writing one to it. When the flags are enabled by the mask, any raised flag pulls an active-low interrupt line down. A host read of an energy register can optionally zero it, which lets software collect energy in increments without losing counts.

Top module: `eq_quantizer`

## Requirements
- R1: After reset (rstN low) all energy registers read 0, halfFull is 3'b000 and irqN is 1.
- R2: On each clock edge where sampleEn is 1, the power of each phase (voltage times current, signed) is added to that phase's accumulator. If the sum is at or above `threshold`, the phase's energy register counts up by one and `threshold` is subtracted from the accumulator. If the sum is at or below minus `threshold`, the register counts down by one and `threshold` is added back. The new value is visible after that edge. At most one quantum per phase is counted per sample, so the power magnitude is intended to stay at or below `threshold`.
- R3: With sampleEn at 0 the energy registers do not change. A `threshold` of zero produces no quanta.
- R4: comboSel selects the phase-B input. 2'b00 uses vB·iB. 2'b01 forces phase-B power to zero. 2'b10 uses (−vA−vC)·iB. 2'b11 uses (−vA)·iB. vB is ignored in all modes except 2'b00. Phases A and C always use vA·iA and vC·iC.
- R5: An energy register saturates at 2^(E_W−1)−1 and at −2^(E_W−1) and never wraps. The accumulator still gives up the threshold at saturation.
- R6: halfFull bit 0, 1 or 2 (phase A, B, C) sets on the clock edge at which that register's magnitude moves from below 2^(E_W−2) to at or above it. The bit does not set again while the register stays in that range.
- R7: Writing statClr with bit i at 1 clears halfFull bit i. If a crossing occurs in the same cycle, the set takes priority.
- R8: irqN is 0 exactly when irqMask is 1 and at least one halfFull bit is 1. Otherwise irqN is 1.
- R9: A read strobe (rdStrobe bit i) with rdClrEn at 0 leaves the register unchanged.
- R10: A read strobe with rdClrEn at 1 sets that register to 0 after the edge, while the other phases are unaffected. If a quantum arrives in the same cycle, the register becomes 0 plus that quantum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleEn | input | 1 | Sample strobe, one per sample period |
| comboSel | input | 2 | Phase-combination select |
| vA | input | V_W (16) | Phase A voltage sample, signed |
| iA | input | I_W (16) | Phase A current sample, signed |
| vB | input | V_W (16) | Phase B voltage sample, signed |
| iB | input | I_W (16) | Phase B current sample, signed |
| vC | input | V_W (16) | Phase C voltage sample, signed |
| iC | input | I_W (16) | Phase C current sample, signed |
| threshold | input | T_W (48) | Energy quantum size, unsigned |
| rdClrEn | input | 1 | Read-with-reset enable |
| rdStrobe | input | 3 | Host read strobes, one per phase |
| statClr | input | 3 | Write-one-to-clear for halfFull |
| irqMask | input | 1 | Enables the half-full interrupt |
| energyA | output | E_W (32) | Phase A energy register, signed |
| energyB | output | E_W (32) | Phase B energy register, signed |
| energyC | output | E_W (32) | Phase C energy register, signed |
| halfFull | output | 3 | Sticky half-full flags |
| irqN | output | 1 | Interrupt, active low |

## Verification
The hardest states to reach are the half-full crossing and saturation. At the default 32-bit width, they need on the order of 2^30 quanta, far more than any run can afford. The bench therefore builds the block with a 10-bit energy register and uses power equal to the threshold, so that every sample yields exactly one quantum. It then walks a register to one below half range, checks for the crossing, clears the register with a read-with-reset, and climbs it again so the crossing lands in the same cycle as a status clear. A phase driven with negative power covers the negative crossing and negative saturation.

// File: rtl/eq_pkg.sv
package eq_pkg;
  localparam int PHASES = 3;

  typedef enum logic [1:0] {
    COMBO_ALL   = 2'b00,
    COMBO_NOB   = 2'b01,
    COMBO_BSUM  = 2'b10,
    COMBO_BNEGA = 2'b11
  } comboMode_t;

  typedef struct packed {
    logic              accLoad;
    logic [PHASES-1:0] quantUp;
    logic [PHASES-1:0] quantDn;
    logic [PHASES-1:0] zeroReg;
  } eqStrobe_t;
endpackage

// File: rtl/eq_combiner.sv
module eq_combiner #(
  parameter int V_W = 16,
  parameter int I_W = 16,
  parameter int P_W = 34
) (
  input  logic [1:0]                comboSel,
  input  logic [V_W-1:0]            vA,
  input  logic [I_W-1:0]            iA,
  input  logic [V_W-1:0]            vB,
  input  logic [I_W-1:0]            iB,
  input  logic [V_W-1:0]            vC,
  input  logic [I_W-1:0]            iC,
  output logic [eq_pkg::PHASES*P_W-1:0] powerBus
);
  import eq_pkg::*;

  logic signed [P_W-1:0] vAw, vBw, vCw, iAw, iBw, iCw, vBeff;
  logic signed [P_W-1:0] pA, pB, pC;

  assign vAw = {{(P_W-V_W){vA[V_W-1]}}, vA};
  assign vBw = {{(P_W-V_W){vB[V_W-1]}}, vB};
  assign vCw = {{(P_W-V_W){vC[V_W-1]}}, vC};
  assign iAw = {{(P_W-I_W){iA[I_W-1]}}, iA};
  assign iBw = {{(P_W-I_W){iB[I_W-1]}}, iB};
  assign iCw = {{(P_W-I_W){iC[I_W-1]}}, iC};

  always_comb begin
    case (comboMode_t'(comboSel))
      COMBO_ALL:  vBeff = vBw;
      COMBO_NOB:  vBeff = '0;
      COMBO_BSUM: vBeff = -vAw - vCw;
      default:    vBeff = -vAw;
    endcase
  end

  assign pA = vAw * iAw;
  assign pB = vBeff * iBw;
  assign pC = vCw * iCw;

  assign powerBus = {pC, pB, pA};
endmodule

// File: rtl/eq_datapath.sv
module eq_datapath #(
  parameter int P_W   = 34,
  parameter int ACC_W = 56,
  parameter int T_W   = 48,
  parameter int E_W   = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [eq_pkg::PHASES*P_W-1:0]     powerBus,
  input  logic [T_W-1:0]                    threshold,
  input  eq_pkg::eqStrobe_t                 strobes,
  output logic [eq_pkg::PHASES*E_W-1:0]     energyBus,
  output logic [eq_pkg::PHASES-1:0]         overThr,
  output logic [eq_pkg::PHASES-1:0]         underThr,
  output logic [eq_pkg::PHASES-1:0]         halfCross
);
  import eq_pkg::*;

  localparam logic signed [E_W-1:0] E_MAX  = {1'b0, {(E_W-1){1'b1}}};
  localparam logic signed [E_W-1:0] E_MIN  = {1'b1, {(E_W-1){1'b0}}};
  localparam logic signed [E_W-1:0] E_HALF = {2'b01, {(E_W-2){1'b0}}};
  localparam logic signed [E_W-1:0] E_NHALF = {2'b11, {(E_W-2){1'b0}}};

  function automatic logic inRange(input logic signed [E_W-1:0] x);
    return (x >= E_HALF) || (x <= E_NHALF);
  endfunction

  logic signed [ACC_W-1:0] thrPos, thrNeg;
  logic                    thrNz;

  assign thrPos = {{(ACC_W-T_W){1'b0}}, threshold};
  assign thrNeg = -thrPos;
  assign thrNz  = |threshold;

  for (genvar g = 0; g < PHASES; g++) begin : gPhase
    logic signed [P_W-1:0]   pw;
    logic signed [ACC_W-1:0] pwExt, accQ, sumNext, accNext;
    logic signed [E_W-1:0]   enQ, enBase, enNext;

    assign pw      = powerBus[g*P_W +: P_W];
    assign pwExt   = {{(ACC_W-P_W){pw[P_W-1]}}, pw};
    assign sumNext = accQ + pwExt;

    assign overThr[g]  = thrNz && (sumNext >= thrPos);
    assign underThr[g] = thrNz && (sumNext <= thrNeg);

    always_comb begin
      accNext = sumNext;
      if (strobes.quantUp[g])      accNext = sumNext - thrPos;
      else if (strobes.quantDn[g]) accNext = sumNext + thrPos;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                accQ <= '0;
      else if (strobes.accLoad) accQ <= accNext;
    end

    always_comb begin
      enBase = strobes.zeroReg[g] ? '0 : enQ;
      enNext = enBase;
      if (strobes.quantUp[g] && enBase != E_MAX)      enNext = enBase + E_W'(1);
      else if (strobes.quantDn[g] && enBase != E_MIN) enNext = enBase - E_W'(1);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) enQ <= '0;
      else       enQ <= enNext;
    end

    assign halfCross[g] = inRange(enNext) && !inRange(enQ);
    assign energyBus[g*E_W +: E_W] = enQ;
  end
endmodule

// File: rtl/eq_control.sv
module eq_control (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sampleEn,
  input  logic                      rdClrEn,
  input  logic [eq_pkg::PHASES-1:0] rdStrobe,
  input  logic [eq_pkg::PHASES-1:0] statClr,
  input  logic                      irqMask,
  input  logic [eq_pkg::PHASES-1:0] overThr,
  input  logic [eq_pkg::PHASES-1:0] underThr,
  input  logic [eq_pkg::PHASES-1:0] halfCross,
  output eq_pkg::eqStrobe_t         strobes,
  output logic [eq_pkg::PHASES-1:0] halfFull,
  output logic                      irqN
);
  import eq_pkg::*;

  always_comb begin
    strobes.accLoad = sampleEn;
    strobes.quantUp = {PHASES{sampleEn}} & overThr;
    strobes.quantDn = {PHASES{sampleEn}} & underThr & ~overThr;
    strobes.zeroReg = rdStrobe & {PHASES{rdClrEn}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) halfFull <= '0;
    else       halfFull <= (halfFull & ~statClr) | halfCross;
  end

  assign irqN = !(irqMask && (|halfFull));
endmodule

// File: rtl/eq_quantizer.sv
module eq_quantizer #(
  parameter int V_W   = 16,
  parameter int I_W   = 16,
  parameter int T_W   = 48,
  parameter int ACC_W = 56,
  parameter int E_W   = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           sampleEn,
  input  logic [1:0]     comboSel,
  input  logic [V_W-1:0] vA,
  input  logic [I_W-1:0] iA,
  input  logic [V_W-1:0] vB,
  input  logic [I_W-1:0] iB,
  input  logic [V_W-1:0] vC,
  input  logic [I_W-1:0] iC,
  input  logic [T_W-1:0] threshold,
  input  logic           rdClrEn,
  input  logic [2:0]     rdStrobe,
  input  logic [2:0]     statClr,
  input  logic           irqMask,
  output logic [E_W-1:0] energyA,
  output logic [E_W-1:0] energyB,
  output logic [E_W-1:0] energyC,
  output logic [2:0]     halfFull,
  output logic           irqN
);
  import eq_pkg::*;

  localparam int P_W = V_W + I_W + 2;

  logic [PHASES*P_W-1:0] powerBus;
  logic [PHASES*E_W-1:0] energyBus;
  logic [PHASES-1:0]     overThr, underThr, halfCross;
  eqStrobe_t             strobes;

  eq_combiner #(.V_W(V_W), .I_W(I_W), .P_W(P_W)) u_comb (
    .comboSel(comboSel), .vA(vA), .iA(iA), .vB(vB), .iB(iB),
    .vC(vC), .iC(iC), .powerBus(powerBus)
  );

  eq_datapath #(.P_W(P_W), .ACC_W(ACC_W), .T_W(T_W), .E_W(E_W)) u_dp (
    .clk(clk), .rstN(rstN), .powerBus(powerBus), .threshold(threshold),
    .strobes(strobes), .energyBus(energyBus), .overThr(overThr),
    .underThr(underThr), .halfCross(halfCross)
  );

  eq_control u_ctl (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .rdClrEn(rdClrEn),
    .rdStrobe(rdStrobe), .statClr(statClr), .irqMask(irqMask),
    .overThr(overThr), .underThr(underThr), .halfCross(halfCross),
    .strobes(strobes), .halfFull(halfFull), .irqN(irqN)
  );

  assign energyA = energyBus[0*E_W +: E_W];
  assign energyB = energyBus[1*E_W +: E_W];
  assign energyC = energyBus[2*E_W +: E_W];
endmodule

// File: rtl/eq_checker.sv
module eq_checker #(
  parameter int T_W = 48,
  parameter int E_W = 32
) (
  input logic           clk,
  input logic           rstN,
  input logic           sampleEn,
  input logic [T_W-1:0] threshold,
  input logic           rdClrEn,
  input logic [2:0]     rdStrobe,
  input logic [2:0]     statClr,
  input logic           irqMask,
  input logic [E_W-1:0] energyA,
  input logic [E_W-1:0] energyB,
  input logic [E_W-1:0] energyC,
  input logic [2:0]     halfFull,
  input logic           irqN
);
  localparam logic [E_W-1:0] E_MAX = {1'b0, {(E_W-1){1'b1}}};
  localparam logic [E_W-1:0] E_MIN = {1'b1, {(E_W-1){1'b0}}};
  localparam logic [E_W-1:0] E_ONE = E_W'(1);

  logic [E_W-1:0] en [3];
  assign en[0] = energyA;
  assign en[1] = energyB;
  assign en[2] = energyC;

  for (genvar g = 0; g < 3; g++) begin : gChk
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
      (en[g] == E_MAX) |=> (en[g] != E_MIN));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!sampleEn && !(rdStrobe[g] && rdClrEn)) |=> $stable(en[g]));

    assert_zero_thr_R3: assert property (@(posedge clk) disable iff (!rstN)
      ((threshold == '0) && !(rdStrobe[g] && rdClrEn)) |=> $stable(en[g]));

    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rstN)
      !(rdStrobe[g] && rdClrEn) |=>
        (en[g] == $past(en[g]) || en[g] == $past(en[g]) + E_ONE ||
         en[g] == $past(en[g]) - E_ONE));

    assert_rd_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
      (rdStrobe[g] && rdClrEn) |=>
        (en[g] == '0 || en[g] == E_ONE || en[g] == ~'0));

    assert_flag_source_R6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(halfFull[g]) |-> $past(sampleEn));

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
      (statClr[g] && !sampleEn) |=> !halfFull[g]);
  end

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rstN)
    !irqMask |-> irqN);
endmodule

bind eq_quantizer eq_checker #(.T_W(T_W), .E_W(E_W)) u_chk (.*);

// File: tb/sim_eq_quantizer.sv
module sim_eq_quantizer;
  localparam int V_W = 16;
  localparam int I_W = 16;
  localparam int T_W = 48;
  localparam int E_W = 10;
  localparam int NV  = 7;
  // fields: mode, vA, iA, vB, iB, vC, iC, thr, expA, expB, expC
  localparam int VEC [NV][11] = '{
    '{0,  10, 10,   5, 18,  -7, 13, 100,  4,  3, -3},
    '{1,  10,  5, 100,100,   9,  9, 100,  2,  0,  3},
    '{2,   6, 10,  55, -9,   4, 25, 100,  2,  3,  4},
    '{3,  -5, 20,  77, 20,   0, 50, 100, -4,  4,  0},
    '{0,   0,  0,   0,  0,   0,  0, 100,  0,  0,  0},
    '{0,   9, 11, -10, 10,   1,  1, 100,  3, -4,  0},
    '{0,  10, 10,  10, 10,  10, 10,   0,  0,  0,  0}
  };

  logic clk = 0, rstN = 0, sampleEn = 0, rdClrEn = 0, irqMask = 0;
  logic [1:0] comboSel = 0;
  logic [V_W-1:0] vA = 0, vB = 0, vC = 0;
  logic [I_W-1:0] iA = 0, iB = 0, iC = 0;
  logic [T_W-1:0] threshold = 0;
  logic [2:0] rdStrobe = 0, statClr = 0, halfFull;
  logic [E_W-1:0] energyA, energyB, energyC;
  logic irqN;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  eq_quantizer #(.V_W(V_W), .I_W(I_W), .T_W(T_W), .E_W(E_W)) u0 (.*);

  function automatic int sx(input logic [E_W-1:0] x);
    return int'($signed(x));
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 0; sampleEn = 0; rdStrobe = 0; statClr = 0; rdClrEn = 0;
    tick(); tick();
    rstN = 1;
    tick();
  endtask

  task automatic samples(input int n);
    sampleEn = 1;
    for (int k = 0; k < n; k++) tick();
    sampleEn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    check("R1 energyA", sx(energyA), 0);
    check("R1 energyB", sx(energyB), 0);
    check("R1 energyC", sx(energyC), 0);
    check("R1 halfFull", int'(halfFull), 0);
    check("R1 irqN", int'(irqN), 1);

    for (int r = 0; r < NV; r++) begin
      string tag;
      doReset();
      comboSel  = 2'(VEC[r][0]);
      vA = 16'(VEC[r][1]); iA = 16'(VEC[r][2]);
      vB = 16'(VEC[r][3]); iB = 16'(VEC[r][4]);
      vC = 16'(VEC[r][5]); iC = 16'(VEC[r][6]);
      threshold = T_W'(VEC[r][7]);
      samples(4);
      tag = (VEC[r][7] == 0) ? "R3" : ((VEC[r][0] == 0) ? "R2" : "R4");
      check({tag, " energyA"}, sx(energyA), VEC[r][8]);
      check({tag, " energyB"}, sx(energyB), VEC[r][9]);
      check({tag, " energyC"}, sx(energyC), VEC[r][10]);
    end

    // R3 idle, R9 plain read, R10 read-with-reset
    doReset();
    comboSel = 0; threshold = 100;
    vA = 10; iA = 10; vB = 10; iB = 10; vC = 0; iC = 0;
    samples(2);
    for (int k = 0; k < 5; k++) tick();
    check("R3 idle energyA", sx(energyA), 2);
    rdStrobe = 3'b001; rdClrEn = 0; tick(); rdStrobe = 0;
    check("R9 plain read energyA", sx(energyA), 2);
    rdStrobe = 3'b001; rdClrEn = 1; tick(); rdStrobe = 0;
    check("R10 cleared energyA", sx(energyA), 0);
    check("R10 other phase energyB", sx(energyB), 2);
    samples(3);
    rdStrobe = 3'b001; sampleEn = 1; tick(); rdStrobe = 0; sampleEn = 0; rdClrEn = 0;
    check("R10 clear plus quantum energyA", sx(energyA), 1);

    // R6/R7/R8/R5 half-full, clearing, interrupt, saturation
    doReset();
    comboSel = 0; threshold = 100; irqMask = 1;
    vA = 10; iA = 10; vB = 0; iB = 0; vC = -10; iC = 10;
    samples(255);
    check("R6 below half energyA", sx(energyA), 255);
    check("R6 below half flags", int'(halfFull), 0);
    check("R8 irqN idle", int'(irqN), 1);
    samples(1);
    check("R6 crossing flags", int'(halfFull), 5);
    check("R8 irqN asserted", int'(irqN), 0);
    irqMask = 0; #1;
    check("R8 irqN masked", int'(irqN), 1);
    irqMask = 1; #1;
    statClr = 3'b001; tick(); statClr = 0;
    check("R7 clear phase A flags", int'(halfFull), 4);
    check("R8 irqN still low", int'(irqN), 0);
    samples(10);
    check("R6 no re-set while in range", int'(halfFull), 4);
    statClr = 3'b100; tick(); statClr = 0;
    check("R8 irqN released", int'(irqN), 1);
    rdStrobe = 3'b001; rdClrEn = 1; tick(); rdStrobe = 0; rdClrEn = 0;
    samples(255);
    check("R6 re-climb energyA", sx(energyA), 255);
    statClr = 3'b001; sampleEn = 1; tick(); statClr = 0; sampleEn = 0;
    check("R7 set wins over clear", int'(halfFull[0]), 1);
    check("R5 negative saturation energyC", sx(energyC), -512);
    samples(300);
    check("R5 positive saturation energyA", sx(energyA), 511);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule